// File: doc/BRIEF.md
# Packet Framer with Length Insertion

The block turns a bare payload stream of 64-bit words into a complete framed packet. A header template arrives on its own valid/ready handshake and carries the packet type, a timestamp-present flag, an end-of-burst flag, a 12-bit sequence number, 16-bit source and destination identifiers and a 64-bit timestamp. The payload arrives on an AXI4-Stream input, with tlast on its final word. The framed packet leaves on an AXI4-Stream output in this order: a header word, then the timestamp word if the flag is set, then the payload words.

The header holds the packet's byte length, and that value depends on how many payload words there are. So the block stores the whole payload in an internal buffer of parameterised depth before it sends the header. A template flag marks a packet with no payload. For such a packet no input beats are taken and the block sends only the header, or the header and the timestamp. A payload longer than the buffer is read in to its end, then thrown away, and an error pulse is raised. The block takes a new template only after the previous framed packet has fully left.

Top module: `pkt_framer`

## Requirements
- R1: The header word is packed as type[63:62], timestamp flag[61], end-of-burst[60], sequence number[59:48], byte length[47:32], source ID[31:16] and destination ID[15:0].
- R2: The byte length is 8 times the payload word count, plus 16 when the timestamp flag is set or plus 8 when it is clear.
- R3: When the timestamp flag is set, the template timestamp is the output word that follows the header, and no payload word comes before it.
- R4: out_tlast is high on the final word of the framed packet and on no other word. For a packet with no payload, the final word is the header when the timestamp flag is clear and the timestamp word when it is set. The payload words leave in the order they arrived.
- R5: The template length input has no effect on the output. The header always carries the computed length.
- R6: in_tready is high only while a payload is being taken in. out_tvalid stays low until the final payload word (the one with tlast) has been accepted.
- R7: A payload of up to DEPTH words is framed. A payload of more than DEPTH words is accepted up to its tlast and produces no output. ovf_err is then high for exactly the one cycle after that final beat.
- R8: While out_tvalid is high and out_tready is low, out_tvalid, out_tdata and out_tlast hold their values.
- R9: tpl_ready and in_tready are never high together. tpl_ready stays low from the template handshake until the final output beat or the dropped packet's tlast. After reset, tpl_ready is high and in_tready, out_tvalid and ovf_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tpl_valid | input | 1 | Template offered |
| tpl_ready | output | 1 | Template accepted (block idle) |
| tpl_kind | input | 2 | Packet type field |
| tpl_stamped | input | 1 | Timestamp word present |
| tpl_burst_end | input | 1 | End-of-burst flag |
| tpl_seq | input | 12 | Sequence number |
| tpl_len | input | 16 | Length from the caller (ignored) |
| tpl_src | input | 16 | Source identifier |
| tpl_dst | input | 16 | Destination identifier |
| tpl_ts | input | 64 | Timestamp value |
| tpl_nopay | input | 1 | Packet has no payload |
| in_tvalid | input | 1 | Payload beat valid |
| in_tready | output | 1 | Payload beat accepted |
| in_tdata | input | 64 | Payload word |
| in_tlast | input | 1 | Final payload word |
| out_tvalid | output | 1 | Framed word valid |
| out_tready | input | 1 | Downstream ready |
| out_tdata | output | 64 | Framed word |
| out_tlast | output | 1 | Final framed word |
| ovf_err | output | 1 | One-cycle pulse when an oversize payload is dropped |

## Verification
A wrong word count shows in the length field of the very next header. It also shows in the position of out_tlast, which moves early or late by a beat. A wrong write or read pointer leaves the length correct, but the payload words come out reordered or stale, and the first mismatched beat shows it. A wrong control state shows at once as tpl_ready and in_tready both high, as out_tvalid high during a fill, or as a dropped packet leaking out. Random output backpressure exercises the hold rule on every stalled beat.

// File: rtl/pkt_framer_pkg.sv
// Shared types and helpers for the packet framer.
// Assumes 64-bit words and a 16-bit byte length field.
package pkt_framer_pkg;

    typedef struct packed {
        logic [1:0]  kind;
        logic        stamped;
        logic        burst_end;
        logic [11:0] seq;
        logic [15:0] src;
        logic [15:0] dst;
    } frame_tpl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_HDR,
        ST_TS,
        ST_PAY
    } fr_state_t;

    // Byte length: eight bytes per payload word plus the header and optional timestamp.
    function automatic logic [15:0] byte_len(input logic [15:0] words, input logic stamped);
        return (words << 3) + (stamped ? 16'd16 : 16'd8);
    endfunction

    // Pack the template fields and the computed length into a header word.
    function automatic logic [63:0] pack_header(input frame_tpl_t t, input logic [15:0] len);
        return {t.kind, t.stamped, t.burst_end, t.seq, len, t.src, t.dst};
    endfunction

endpackage

// File: rtl/framer_store.sv
// Payload buffer: one write port and one combinational read port.
// Assumes the controller never writes beyond DEPTH-1 and reads only written entries.
module framer_store #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write one payload word per accepted beat.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read the word that the output beat is presenting.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/framer_ctrl.sv
// Sequencing for the framer: idle, fill, then header, timestamp and payload out.
// Counts payload words, detects an oversize payload and raises the drop pulse.
// Assumes DEPTH >= 2; the stamped flag comes from the registered template.
module framer_ctrl
    import pkt_framer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tpl_valid,
    input  logic          tpl_nopay,
    input  logic          stamped,
    input  logic          in_tvalid,
    input  logic          in_tlast,
    input  logic          out_tready,
    output fr_state_t     state,
    output logic [CW-1:0] word_cnt,
    output logic [CW-1:0] rd_idx,
    output logic          wr_en,
    output logic          tpl_take,
    output logic          last_word,
    output logic          drop_pulse
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic oversize;
    logic rd_final;

    // Decode handshakes and the position of the final outgoing word.
    always_comb begin
        tpl_take = (state == ST_IDLE) && tpl_valid;
        wr_en    = (state == ST_FILL) && in_tvalid && (word_cnt != FULL);
        rd_final = (rd_idx == word_cnt - CW'(1));
        case (state)
            ST_HDR:  last_word = (word_cnt == '0) && !stamped;
            ST_TS:   last_word = (word_cnt == '0);
            ST_PAY:  last_word = rd_final;
            default: last_word = 1'b0;
        endcase
    end

    // State, count and pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            word_cnt   <= '0;
            rd_idx     <= '0;
            oversize   <= 1'b0;
            drop_pulse <= 1'b0;
        end else begin
            drop_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tpl_valid) begin
                        word_cnt <= '0;
                        rd_idx   <= '0;
                        oversize <= 1'b0;
                        state    <= tpl_nopay ? ST_HDR : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (in_tvalid) begin
                        if (word_cnt == FULL) begin
                            oversize <= 1'b1;
                        end else begin
                            word_cnt <= word_cnt + CW'(1);
                        end
                        if (in_tlast) begin
                            if (oversize || (word_cnt == FULL)) begin
                                state      <= ST_IDLE;
                                drop_pulse <= 1'b1;
                            end else begin
                                state <= ST_HDR;
                            end
                        end
                    end
                end
                ST_HDR: begin
                    if (out_tready) begin
                        if (last_word)    state <= ST_IDLE;
                        else if (stamped) state <= ST_TS;
                        else              state <= ST_PAY;
                    end
                end
                ST_TS: begin
                    if (out_tready) begin
                        state <= last_word ? ST_IDLE : ST_PAY;
                    end
                end
                ST_PAY: begin
                    if (out_tready) begin
                        rd_idx <= rd_idx + CW'(1);
                        if (last_word) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pkt_framer.sv
// Top of the packet framer: holds the template, buffers one payload and emits
// header, optional timestamp and payload with the computed byte length.
// Assumes the payload source keeps in_tlast on exactly one beat per packet.
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tpl_valid,
    output logic        tpl_ready,
    input  logic [1:0]  tpl_kind,
    input  logic        tpl_stamped,
    input  logic        tpl_burst_end,
    input  logic [11:0] tpl_seq,
    input  logic [15:0] tpl_len,
    input  logic [15:0] tpl_src,
    input  logic [15:0] tpl_dst,
    input  logic [63:0] tpl_ts,
    input  logic        tpl_nopay,
    input  logic        in_tvalid,
    output logic        in_tready,
    input  logic [63:0] in_tdata,
    input  logic        in_tlast,
    output logic        out_tvalid,
    input  logic        out_tready,
    output logic [63:0] out_tdata,
    output logic        out_tlast,
    output logic        ovf_err
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    frame_tpl_t     tpl_q;
    logic [63:0]    ts_q;
    fr_state_t      state;
    logic [CW-1:0]  word_cnt;
    logic [CW-1:0]  rd_idx;
    logic           wr_en;
    logic           tpl_take;
    logic           last_word;
    logic [63:0]    rd_data;
    logic [15:0]    len_calc;

    framer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tpl_valid  (tpl_valid),
        .tpl_nopay  (tpl_nopay),
        .stamped    (tpl_q.stamped),
        .in_tvalid  (in_tvalid),
        .in_tlast   (in_tlast),
        .out_tready (out_tready),
        .state      (state),
        .word_cnt   (word_cnt),
        .rd_idx     (rd_idx),
        .wr_en      (wr_en),
        .tpl_take   (tpl_take),
        .last_word  (last_word),
        .drop_pulse (ovf_err)
    );

    framer_store #(.WORD_W(64), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (word_cnt[AW-1:0]),
        .wr_data (in_tdata),
        .rd_addr (rd_idx[AW-1:0]),
        .rd_data (rd_data)
    );

    // Capture the template on its handshake; the caller's length is not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpl_q <= '0;
            ts_q  <= '0;
        end else if (tpl_take) begin
            tpl_q <= '{kind: tpl_kind, stamped: tpl_stamped, burst_end: tpl_burst_end,
                       seq: tpl_seq, src: tpl_src, dst: tpl_dst};
            ts_q  <= tpl_ts;
        end
    end

    // Handshake levels and the outgoing word selection.
    always_comb begin
        tpl_ready  = (state == ST_IDLE);
        in_tready  = (state == ST_FILL);
        out_tvalid = (state == ST_HDR) || (state == ST_TS) || (state == ST_PAY);
        out_tlast  = last_word;
        len_calc   = byte_len(16'(word_cnt), tpl_q.stamped);
        case (state)
            ST_HDR:  out_tdata = pack_header(tpl_q, len_calc);
            ST_TS:   out_tdata = ts_q;
            ST_PAY:  out_tdata = rd_data;
            default: out_tdata = '0;
        endcase
    end

endmodule

// File: rtl/pkt_framer_chk.sv
// Port-level checker for the packet framer, bound into every instance.
// Tracks accepted payload beats to check the header length independently.
module pkt_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tpl_valid,
    input logic        tpl_ready,
    input logic        tpl_stamped,
    input logic        in_tvalid,
    input logic        in_tready,
    input logic        in_tlast,
    input logic        out_tvalid,
    input logic        out_tready,
    input logic [63:0] out_tdata,
    input logic        out_tlast,
    input logic        ovf_err
);

    logic [15:0] beats;
    logic        stamp_q;
    logic        mid_pkt;

    // Count payload beats since the template and track the output packet position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats   <= '0;
            stamp_q <= 1'b0;
            mid_pkt <= 1'b0;
        end else begin
            if (tpl_valid && tpl_ready) begin
                beats   <= '0;
                stamp_q <= tpl_stamped;
            end else if (in_tvalid && in_tready) begin
                beats <= beats + 16'd1;
            end
            if (out_tvalid && out_tready) begin
                mid_pkt <= !out_tlast;
            end
        end
    end

    assert_len_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !mid_pkt) |->
        (out_tdata[47:32] == ((beats << 3) + (stamp_q ? 16'd16 : 16'd8))) && (out_tdata[61] == stamp_q));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));

    assert_no_early_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_tready && out_tvalid));

    assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tpl_ready, in_tready}));

    assert_drop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> ($past(in_tvalid && in_tready && in_tlast) && !out_tvalid));

endmodule

bind pkt_framer pkt_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tpl_valid   (tpl_valid),
    .tpl_ready   (tpl_ready),
    .tpl_stamped (tpl_stamped),
    .in_tvalid   (in_tvalid),
    .in_tready   (in_tready),
    .in_tlast    (in_tlast),
    .out_tvalid  (out_tvalid),
    .out_tready  (out_tready),
    .out_tdata   (out_tdata),
    .out_tlast   (out_tlast),
    .ovf_err     (ovf_err)
);

// File: tb/pkt_framer_tb.sv
// Bench for pkt_framer: seeded random packets plus directed corner cases.
module pkt_framer_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tpl_valid = 1'b0;
    logic        tpl_ready;
    logic [1:0]  tpl_kind = '0;
    logic        tpl_stamped = 1'b0;
    logic        tpl_burst_end = 1'b0;
    logic [11:0] tpl_seq = '0;
    logic [15:0] tpl_len = '0;
    logic [15:0] tpl_src = '0;
    logic [15:0] tpl_dst = '0;
    logic [63:0] tpl_ts = '0;
    logic        tpl_nopay = 1'b0;
    logic        in_tvalid = 1'b0;
    logic        in_tready;
    logic [63:0] in_tdata = '0;
    logic        in_tlast = 1'b0;
    logic        out_tvalid;
    logic        out_tready = 1'b0;
    logic [63:0] out_tdata;
    logic        out_tlast;
    logic        ovf_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;

    always #10 clk = ~clk;

    pkt_framer #(.DEPTH(DEPTH)) u_dut (.*);

    // Record one check and report a mismatch.
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected header word from the requirement layout and length rule.
    function automatic logic [63:0] exp_header(input logic [1:0] k, input logic s, input logic e,
                                               input logic [11:0] q, input int n,
                                               input logic [15:0] sr, input logic [15:0] ds);
        logic [15:0] len;
        len = 16'(n * 8 + (s ? 16 : 8));
        return {k, s, e, q, len, sr, ds};
    endfunction

    // Offer a template and wait for its handshake (entered and left on a falling edge).
    task automatic send_tpl(input logic [1:0] k, input logic s, input logic e, input logic [11:0] q,
                            input logic [15:0] sr, input logic [15:0] ds, input logic [63:0] ts,
                            input logic nopay);
        tpl_valid = 1'b1; tpl_kind = k; tpl_stamped = s; tpl_burst_end = e; tpl_seq = q;
        tpl_src = sr; tpl_dst = ds; tpl_ts = ts; tpl_nopay = nopay;
        tpl_len = 16'($urandom);
        while (!tpl_ready) @(negedge clk);
        @(negedge clk);
        tpl_valid = 1'b0;
    endtask

    // Push one payload beat; output must stay idle while filling.
    task automatic push_word(input logic [63:0] w, input logic last);
        in_tvalid = 1'b1; in_tdata = w; in_tlast = last;
        while (!in_tready) @(negedge clk);
        check(out_tvalid == 1'b0, "R6 out_tvalid during fill", 64'(out_tvalid), 64'd0);
        @(negedge clk);
        in_tvalid = 1'b0; in_tlast = 1'b0;
    endtask

    // Frame one packet of n payload words and check everything that comes out.
    task automatic run_pkt(input int n, input logic s, input bit full_ready);
        logic [63:0] exp_q[$];
        logic [63:0] pay[$];
        logic [1:0]  k  = 2'($urandom);
        logic        e  = 1'($urandom);
        logic [11:0] q  = 12'($urandom);
        logic [15:0] sr = 16'($urandom);
        logic [15:0] ds = 16'($urandom);
        logic [63:0] ts = {$urandom, $urandom};
        int idx = 0;
        int guard = 0;
        logic [63:0] held_d;
        logic held_l;
        bit held = 1'b0;
        for (int i = 0; i < n; i++) pay.push_back({$urandom, $urandom});
        send_tpl(k, s, e, q, sr, ds, ts, n == 0);
        for (int i = 0; i < n; i++) push_word(pay[i], i == n - 1);
        if (n > DEPTH) begin
            check(ovf_err == 1'b1, "R7 ovf_err after oversize tlast", 64'(ovf_err), 64'd1);
            check(tpl_ready == 1'b1, "R9 idle after drop", 64'(tpl_ready), 64'd1);
            @(negedge clk);
            check(ovf_err == 1'b0, "R7 ovf_err single cycle", 64'(ovf_err), 64'd0);
            check(out_tvalid == 1'b0, "R7 dropped packet not sent", 64'(out_tvalid), 64'd0);
            return;
        end
        exp_q.push_back(exp_header(k, s, e, q, n, sr, ds));
        if (s) exp_q.push_back(ts);
        foreach (pay[i]) exp_q.push_back(pay[i]);
        while (idx < exp_q.size() && guard < 2000) begin
            guard++;
            if (held) begin
                check(out_tvalid && out_tdata == held_d && out_tlast == held_l,
                      "R8 hold under stall", out_tdata, held_d);
                held = 1'b0;
            end
            out_tready = full_ready ? 1'b1 : ($urandom_range(0, 3) != 0);
            if (out_tvalid) begin
                check(tpl_ready == 1'b0, "R9 tpl_ready low while sending", 64'(tpl_ready), 64'd0);
                if (out_tready) begin
                    if (idx == 0)
                        check(out_tdata == exp_q[0], "R1 R2 R5 header word", out_tdata, exp_q[0]);
                    else if (idx == 1 && s)
                        check(out_tdata == ts, "R3 timestamp word", out_tdata, ts);
                    else
                        check(out_tdata == exp_q[idx], "R4 payload word", out_tdata, exp_q[idx]);
                    check(out_tlast == (idx == exp_q.size() - 1), "R4 tlast position",
                          64'(out_tlast), 64'(idx == exp_q.size() - 1));
                    idx++;
                end else begin
                    held = 1'b1; held_d = out_tdata; held_l = out_tlast;
                end
            end
            @(negedge clk);
        end
        out_tready = 1'b0;
        check(idx == exp_q.size(), "R4 word count", 64'(idx), 64'(exp_q.size()));
        check(tpl_ready == 1'b1 && out_tvalid == 1'b0, "R9 idle after last beat",
              {62'd0, tpl_ready, out_tvalid}, 64'd2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tpl_ready == 1'b1, "R9 reset tpl_ready", 64'(tpl_ready), 64'd1);
        check(in_tready == 1'b0 && out_tvalid == 1'b0 && ovf_err == 1'b0, "R9 reset outputs",
              {61'd0, in_tready, out_tvalid, ovf_err}, 64'd0);
        // Directed corners.
        run_pkt(0, 1'b0, 1'b1);      // header only: tlast on header (R4)
        run_pkt(0, 1'b1, 1'b0);      // header + timestamp: tlast on timestamp (R4, R3)
        run_pkt(1, 1'b1, 1'b1);      // single payload word after timestamp (R3)
        run_pkt(DEPTH, 1'b0, 1'b0);  // exactly full buffer is framed (R7)
        run_pkt(DEPTH + 1, 1'b1, 1'b0); // one too many: dropped (R7)
        run_pkt(DEPTH + 5, 1'b0, 1'b0); // longer oversize: dropped (R7)
        run_pkt(3, 1'b0, 1'b0);      // normal packet after a drop (R7)
        // Seeded random packets.
        for (int p = 0; p < 60; p++) begin
            run_pkt($urandom_range(0, DEPTH + 2), 1'($urandom), ($urandom_range(0, 4) == 0));
        end
        if (!timed_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule